// File: doc/BRIEF.md
# Untrusted Batch Store Guard

This block sits beside a command parser and inspects each decoded instruction header as it enters execution. When a ring buffer launches a batch buffer, the launch carries a flag that says whether the batch comes from an untrusted source. That flag sets a protection mode. The mode covers the whole batch sequence, including every batch that the sequence chains to. The mode ends when execution returns to the ring.

While the mode is set, the parser may not execute an immediate store-dword instruction fetched from a batch. That instruction writes system memory directly and does not go through the address translation table. If such an instruction appears, the block records the offending header, where it came from and an error code. It then stops the parser until reset. It can also raise an interrupt request. The request is gated by an enable register and a mask register.

The opcode field that is compared and the opcode value are parameters. The error record holds the first violation only.

Top module: `batch_guard`

## Requirements
- R1: After reset, `prot_mode`, `halt`, `irq`, `err_valid`, `err_hdr`, `err_from_batch`, `err_ring` and `err_code` are all 0. The interrupt enable register resets to 0 and the interrupt mask register resets to 1.
- R2: A batch start issued from a ring (`bstart_valid`=1, `bstart_from_batch`=0) loads `prot_mode` with `bstart_untrusted` on the following cycle.
- R3: A chained batch start (`bstart_valid`=1, `bstart_from_batch`=1) leaves `prot_mode` unchanged. A trusted chained batch therefore cannot leave protected mode.
- R4: `bseq_end`=1 clears `prot_mode` on the following cycle. If a ring-issued batch start arrives in the same cycle, the batch start takes priority.
- R5: A violation occurs when all of these hold in one cycle: `hdr_valid`=1, `hdr_from_batch`=1, `prot_mode`=1, and `hdr_word[OPC_LSB +: OPC_W]` equals `STORE_OPC` (default: bits 28:23 equal 6'h20). On the next cycle after a violation, `halt` is 1.
- R6: Each of the following leaves `halt` at 0: the store opcode arriving from a ring (`hdr_from_batch`=0), the store opcode arriving while `prot_mode` is 0, or any other opcode arriving from a batch in protected mode.
- R7: On the cycle after a violation, the error record is loaded:
  - `err_valid` is 1;
  - `err_hdr` holds the header word;
  - `err_from_batch` and `err_ring` hold the header's origin;
  - `err_code` is 1 (illegal store in a protected batch). Code 0 means no error.
- R8: While `halt` is 1, the block ignores every instruction-stream input: headers, batch starts and `bseq_end`. The error record and `prot_mode` keep their values, so the record always describes the first violation.
- R9: `irq` is 1 exactly when a violation has been recorded, the enable register is 1 and the mask register is 0. A write strobe updates each register, and the new value takes effect on the following cycle, also while halted.
- R10: Once `halt` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | A header is entering execution this cycle |
| hdr_word | input | HDR_W | Instruction header |
| hdr_from_batch | input | 1 | 1: header fetched from a batch buffer; 0: fetched from a ring |
| hdr_ring | input | RING_W | Ring that started the current stream |
| bstart_valid | input | 1 | A batch start is executing |
| bstart_untrusted | input | 1 | Untrusted flag carried by the batch start |
| bstart_from_batch | input | 1 | 1: chained start from inside a batch; 0: issued by a ring |
| bseq_end | input | 1 | The batch sequence ended and execution returns to the ring |
| irq_en_wr | input | 1 | Write strobe for the interrupt enable register |
| irq_en_din | input | 1 | New interrupt enable value |
| irq_mask_wr | input | 1 | Write strobe for the interrupt mask register |
| irq_mask_din | input | 1 | New interrupt mask value |
| prot_mode | output | 1 | Protected mode in force |
| halt | output | 1 | Parser stop request |
| irq | output | 1 | Interrupt request |
| err_valid | output | 1 | Error record holds a violation |
| err_hdr | output | HDR_W | Header of the first violation |
| err_from_batch | output | 1 | Origin of the first violation: batch or ring |
| err_ring | output | RING_W | Ring of the first violation |
| err_code | output | ERR_W | Error code (0 none, 1 illegal store) |

## Verification
Several header streams are applied, each designed to isolate one term of the violation condition:
- the store opcode from a ring while protected;
- the store opcode from a batch while unprotected;
- a different opcode from a batch while protected;
- the full violating combination.

A halt in any case other than the last points to one missing term. Mode handling is tried with four patterns:
- trusted and untrusted ring launches;
- a trusted chained launch inside an untrusted sequence;
- a sequence end on its own;
- a sequence end that coincides with a new ring launch.

These separate the load, hold, clear and priority behaviour of the mode. After the halt, a second violating header, new launches and a sequence end are applied to show that the first record stays. Interrupt enable and mask writes come both before and after a violation, so that every gating combination appears at `irq`.

// File: rtl/batch_guard.sv
module batch_guard #(
  parameter int HDR_W = 32,
  parameter int OPC_LSB = 23,
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] STORE_OPC = 6'h20,
  parameter int RING_W = 2,
  parameter int ERR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [HDR_W-1:0]  hdr_word,
  input  logic              hdr_from_batch,
  input  logic [RING_W-1:0] hdr_ring,
  input  logic              bstart_valid,
  input  logic              bstart_untrusted,
  input  logic              bstart_from_batch,
  input  logic              bseq_end,
  input  logic              irq_en_wr,
  input  logic              irq_en_din,
  input  logic              irq_mask_wr,
  input  logic              irq_mask_din,
  output logic              prot_mode,
  output logic              halt,
  output logic              irq,
  output logic              err_valid,
  output logic [HDR_W-1:0]  err_hdr,
  output logic              err_from_batch,
  output logic [RING_W-1:0] err_ring,
  output logic [ERR_W-1:0]  err_code
);

  localparam logic [ERR_W-1:0] ERR_NONE  = '0;
  localparam logic [ERR_W-1:0] ERR_STORE = ERR_W'(1);

  logic irq_en_q, irq_mask_q, irq_pend_q;

  wire opc_hit    = hdr_word[OPC_LSB +: OPC_W] == STORE_OPC;
  wire violation  = !halt && hdr_valid && hdr_from_batch && prot_mode && opc_hit;
  wire ring_start = !halt && bstart_valid && !bstart_from_batch;
  wire seq_close  = !halt && bseq_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prot_mode <= 1'b0;
    else if (ring_start) prot_mode <= bstart_untrusted;
    else if (seq_close)  prot_mode <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt           <= 1'b0;
      err_valid      <= 1'b0;
      err_hdr        <= '0;
      err_from_batch <= 1'b0;
      err_ring       <= '0;
      err_code       <= ERR_NONE;
      irq_pend_q     <= 1'b0;
    end else if (violation) begin
      halt           <= 1'b1;
      err_valid      <= 1'b1;
      err_hdr        <= hdr_word;
      err_from_batch <= hdr_from_batch;
      err_ring       <= hdr_ring;
      err_code       <= ERR_STORE;
      irq_pend_q     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q   <= 1'b0;
      irq_mask_q <= 1'b1;
    end else begin
      if (irq_en_wr)   irq_en_q   <= irq_en_din;
      if (irq_mask_wr) irq_mask_q <= irq_mask_din;
    end
  end

  assign irq = irq_pend_q & irq_en_q & ~irq_mask_q;

endmodule

module batch_guard_chk #(
  parameter int HDR_W = 32,
  parameter int OPC_LSB = 23,
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] STORE_OPC = 6'h20,
  parameter int RING_W = 2,
  parameter int ERR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic [HDR_W-1:0]  hdr_word,
  input logic              hdr_from_batch,
  input logic              bstart_valid,
  input logic              bstart_untrusted,
  input logic              bstart_from_batch,
  input logic              bseq_end,
  input logic              prot_mode,
  input logic              halt,
  input logic              irq,
  input logic              irq_en_q,
  input logic              irq_mask_q,
  input logic              err_valid,
  input logic [HDR_W-1:0]  err_hdr,
  input logic [RING_W-1:0] err_ring,
  input logic [ERR_W-1:0]  err_code
);

  wire bad_hdr = hdr_valid && hdr_from_batch && prot_mode
                 && (hdr_word[OPC_LSB +: OPC_W] == STORE_OPC);

  AST_RING_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && bstart_valid && !bstart_from_batch |=> prot_mode == $past(bstart_untrusted)); // R2
  AST_CHAIN_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && bstart_valid && bstart_from_batch && !bseq_end |=> prot_mode == $past(prot_mode)); // R3
  AST_SEQ_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && bseq_end && !(bstart_valid && !bstart_from_batch) |=> !prot_mode); // R4
  AST_VIOLATION_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && bad_hdr |=> halt && err_valid && err_code == ERR_W'(1) && err_hdr == $past(hdr_word)); // R5
  AST_NO_FALSE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && !bad_hdr |=> !halt); // R6
  AST_HALT_HAS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> err_valid && err_code == ERR_W'(1)); // R7
  AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(err_hdr) && $stable(err_ring) && $stable(err_code) && $stable(prot_mode)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> halt && irq_en_q && !irq_mask_q); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt); // R10

endmodule

bind batch_guard batch_guard_chk #(
  .HDR_W(HDR_W), .OPC_LSB(OPC_LSB), .OPC_W(OPC_W), .STORE_OPC(STORE_OPC),
  .RING_W(RING_W), .ERR_W(ERR_W)
) u_chk (.*);

// File: tb/batch_guard_bench.sv
module batch_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HDR_W = 32;
  localparam int OPC_LSB = 23;
  localparam int RING_W = 2;
  localparam int ERR_W = 2;
  localparam logic [31:0] ST_HDR_A  = 32'h1000_0005;
  localparam logic [31:0] ST_HDR_B  = 32'h1000_00AA;
  localparam logic [31:0] OTHER_HDR = 32'h0880_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 0, hdr_from_batch = 0, bstart_valid = 0, bstart_untrusted = 0;
  logic bstart_from_batch = 0, bseq_end = 0;
  logic irq_en_wr = 0, irq_en_din = 0, irq_mask_wr = 0, irq_mask_din = 0;
  logic [HDR_W-1:0] hdr_word = '0;
  logic [RING_W-1:0] hdr_ring = '0;
  logic prot_mode, halt, irq, err_valid, err_from_batch;
  logic [HDR_W-1:0] err_hdr;
  logic [RING_W-1:0] err_ring;
  logic [ERR_W-1:0] err_code;

  int checks = 0, errors = 0;
  bit done = 0;

  batch_guard u_batch_guard (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit m_prot, m_halt, m_en, m_mask, m_pend, m_fb;
  int unsigned m_ring, m_code;
  logic [31:0] m_log[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prot = 0; m_halt = 0; m_en = 0; m_mask = 1; m_pend = 0;
      m_fb = 0; m_ring = 0; m_code = 0; m_log.delete();
    end else begin
      bit was_halted, store_like;
      was_halted = m_halt;
      store_like = hdr_valid && hdr_from_batch && m_prot && (((hdr_word >> OPC_LSB) & 32'h3F) == 32'h20);
      if (store_like) begin
        m_log.push_back(hdr_word);
        if (!was_halted) begin
          m_halt = 1; m_pend = 1; m_code = 1; m_fb = hdr_from_batch; m_ring = hdr_ring;
        end
      end
      if (!was_halted) begin
        if (bstart_valid && !bstart_from_batch) m_prot = bstart_untrusted;
        else if (bseq_end) m_prot = 0;
      end
      if (irq_en_wr) m_en = irq_en_din;
      if (irq_mask_wr) m_mask = irq_mask_din;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2 R3 R4", "prot_mode", 32'(prot_mode), 32'(m_prot));
    check("R5 R6 R10", "halt", 32'(halt), 32'(m_halt));
    check("R7", "err_valid", 32'(err_valid), 32'(m_halt));
    check("R7 R8", "err_hdr", err_hdr, m_log.size() > 0 ? m_log[0] : 32'h0);
    check("R7", "err_from_batch", 32'(err_from_batch), 32'(m_fb));
    check("R7", "err_ring", 32'(err_ring), 32'(m_ring));
    check("R7", "err_code", 32'(err_code), 32'(m_code));
    check("R9", "irq", 32'(irq), 32'(m_pend & m_en & ~m_mask));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    hdr_valid = 0; hdr_from_batch = 0; hdr_word = '0; hdr_ring = '0;
    bstart_valid = 0; bstart_untrusted = 0; bstart_from_batch = 0; bseq_end = 0;
    irq_en_wr = 0; irq_mask_wr = 0;
  endtask

  task automatic hdr(logic [31:0] w, logic fb, logic [RING_W-1:0] r);
    hdr_valid = 1; hdr_word = w; hdr_from_batch = fb; hdr_ring = r;
  endtask

  task automatic bstart(logic untrusted, logic chained);
    bstart_valid = 1; bstart_untrusted = untrusted; bstart_from_batch = chained;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    tick(); tick();
    check("R1", "reset halt", 32'(halt), 0);
    check("R1", "reset prot_mode", 32'(prot_mode), 0);
    check("R1", "reset err_code", 32'(err_code), 0);
    check("R1", "reset err_hdr", err_hdr, 0);
    check("R1", "reset irq", 32'(irq), 0);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    bstart(0, 0); tick();
    hdr(ST_HDR_A, 1, 2'd0); tick();
    check("R6", "store while unprotected", 32'(halt), 0);
    bstart(1, 0); tick();
    check("R2", "untrusted ring start", 32'(prot_mode), 1);
    bstart(0, 1); tick();
    check("R3", "trusted chained start keeps mode", 32'(prot_mode), 1);
    hdr(ST_HDR_A, 0, 2'd1); tick();
    check("R6", "store from ring", 32'(halt), 0);
    hdr(OTHER_HDR, 1, 2'd1); tick();
    check("R6", "other opcode from batch", 32'(halt), 0);
    bseq_end = 1; tick();
    check("R4", "sequence end clears", 32'(prot_mode), 0);
    hdr(ST_HDR_A, 1, 2'd0); tick();
    bstart(1, 0); bseq_end = 1; tick();
    check("R4", "ring start wins over end", 32'(prot_mode), 1);
    irq_en_wr = 1; irq_en_din = 1; tick();
    hdr(ST_HDR_A, 1, 2'd2); tick();
    check("R5", "violation halts", 32'(halt), 1);
    check("R7", "error header", err_hdr, ST_HDR_A);
    check("R7", "error ring", 32'(err_ring), 2);
    check("R7", "error code", 32'(err_code), 1);
    check("R9", "masked irq", 32'(irq), 0);
    irq_mask_wr = 1; irq_mask_din = 0; tick();
    check("R9", "unmasked irq", 32'(irq), 1);
    hdr(ST_HDR_B, 1, 2'd3); tick();
    check("R8", "second violation ignored", err_hdr, ST_HDR_A);
    bstart(0, 0); tick();
    bseq_end = 1; tick();
    check("R8", "mode frozen while halted", 32'(prot_mode), 1);
    repeat (5) tick();
    check("R10", "halt sticky", 32'(halt), 1);
    irq_en_wr = 1; irq_en_din = 0; tick();
    check("R9", "disabled irq", 32'(irq), 0);
    do_reset();
    bstart(1, 0); tick();
    irq_mask_wr = 1; irq_mask_din = 0; tick();
    hdr(ST_HDR_B, 1, 2'd1); tick();
    check("R9", "irq not enabled", 32'(irq), 0);
    check("R7", "record after reset", err_hdr, ST_HDR_B);
    irq_en_wr = 1; irq_en_din = 1; tick();
    check("R9", "irq after enable", 32'(irq), 1);
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule